// File: doc/BRIEF.md
# Wait-State Register File Slave

This block places a small array of data-width registers behind a minimal address bus. A master asserts a start level and holds address, byte enables, write data and a read-not-write flag steady. The slave answers each transaction with a single-cycle done pulse after a configurable number of wait cycles. Read data and an error flag travel with that pulse and are meaningful only in that cycle.

Byte enables qualify both directions. On a write, only the enabled byte lanes change. On a read, the disabled lanes come back as zero. The address is a byte address. The bits below the word size are dropped, and a word index past the end of the array completes with an error and has no effect on the registers.

Top module: `sbus_regfile`

## Requirements
- R1: Start is treated as a level. The done output is high in the cycle that follows the WAIT_CYC-th consecutive rising edge at which start is sampled high, so the default of 3 gives done on the cycle after the third such edge.
- R2: Done is high for exactly one cycle per transaction. A start still high at the edge that closes the done cycle is not counted, so a master that keeps start high sees the next done only after WAIT_CYC further edges.
- R3: A write to an in-range word changes byte lane i (bits 8i+7 to 8i) only when byte enable bit i is 1.
- R4: A read of an in-range word returns the register contents in the enabled lanes and zero in the disabled lanes.
- R5: The read data output is zero in every cycle in which done is low, and also for write transactions.
- R6: A word index of NUM_REGS or more completes with done and error both high and read data zero, and it leaves every register unchanged.
- R7: The error output is high only together with done, and it is low for in-range transactions.
- R8: The word index is the address shifted right by log2(DATA_W/8), which is 2 for 32-bit data. The low address bits have no effect.
- R9: After reset all registers read as zero, and done, error and read data are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_start | input | 1 | Transaction request level, held until done |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | DATA_W/8 | Byte lane enables |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the done cycle |
| bus_done | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Error, valid in the done cycle |

## Verification
The response is due in the cycle after the WAIT_CYC-th sampling edge of start. For a start that is kept high across the closing edge of a done cycle, the response is due one edge later. The driver raises start on a falling edge and counts the falling edges until it first sees done, then compares that count with the due value. Read data and the error flag are compared by a monitor that samples on falling edges. In each done cycle it pops the next expected item from the queue, and in every other cycle it requires both outputs to be low, so a done that comes early or is unexpected shows up as a mismatch.

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int WAIT_CYC = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_start,
  input  logic                bus_rnw,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_done,
  output logic                bus_err
);
  localparam int BYTES = DATA_W / 8;
  localparam int LSB   = $clog2(BYTES);
  localparam int IDX_W = ADDR_W - LSB;
  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam logic [IDX_W:0] NREG = NUM_REGS[IDX_W:0];
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 1);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] lane_mask;

  wire [IDX_W-1:0] idx      = bus_addr[ADDR_W-1:LSB];
  wire [SEL_W-1:0] sel      = idx[SEL_W-1:0];
  wire             in_range = {1'b0, idx} < NREG;
  wire             fire     = bus_start && !bus_done && (cnt == LAST);

  for (genvar b = 0; b < BYTES; b++) begin : g_mask
    assign lane_mask[8*b +: 8] = {8{bus_be[b]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (!bus_start || bus_done)  cnt <= '0;
    else if (cnt == LAST)             cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_done  <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_done  <= fire;
      bus_err   <= fire && !in_range;
      bus_rdata <= (fire && in_range && bus_rnw) ? (regs[sel] & lane_mask) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) regs[r] <= '0;
    end else if (fire && in_range && !bus_rnw) begin
      for (int b = 0; b < BYTES; b++)
        if (bus_be[b]) regs[sel][8*b +: 8] <= bus_wdata[8*b +: 8];
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done |=> !bus_done);
  // R1
  done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done |-> $past(bus_start));
  // R7
  err_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_done);
  // R5
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_done |-> (bus_rdata == '0));
  // R6
  err_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0));
endmodule

// File: tb/tb_sbus_regfile.sv
`timescale 1ns/1ps
module tb_sbus_regfile;
  localparam int WAIT = 3;
  localparam int NR   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_start = 1'b0;
  logic        bus_rnw = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_done;
  logic        bus_err;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [NR];
  logic [31:0] q_data [$];
  logic        q_err [$];
  string       q_tag [$];
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  sbus_regfile #(.ADDR_W(16), .DATA_W(32), .NUM_REGS(NR), .WAIT_CYC(WAIT)) dut (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_rnw(bus_rnw),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_done(bus_done), .bus_err(bus_err));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares the response of each done cycle with the queue (R4 R5 R6 R7)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (bus_done) begin
        if (q_data.size() == 0) begin
          check(1'b0, "R2 unexpected done", 32'd1, 32'd0);
        end else begin
          logic [31:0] ed;
          logic ee;
          string t;
          ed = q_data.pop_front();
          ee = q_err.pop_front();
          t  = q_tag.pop_front();
          check(bus_rdata == ed, {t, " rdata"}, bus_rdata, ed);
          check(bus_err == ee, {t, " err"}, {31'd0, bus_err}, {31'd0, ee});
        end
      end else if (bus_rdata != '0 || bus_err) begin
        check(1'b0, "R5 R7 outputs outside done", bus_rdata, 32'd0);
      end
    end
  end

  // Driver: predicts, queues, drives, then checks the done latency (R1 R2)
  task automatic xact(input logic [15:0] a, input logic [31:0] wd, input logic [3:0] be,
                      input logic rnw, input bit keep, input int exp_n, input string tag);
    int idx;
    logic [31:0] m;
    logic [31:0] ed;
    int n;
    idx = int'(a >> 2);
    for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
    ed = '0;
    if (idx < NR) begin
      if (rnw) ed = model[idx] & m;
      else     model[idx] = (model[idx] & ~m) | (wd & m);
    end
    q_data.push_back(ed);
    q_err.push_back(idx >= NR);
    q_tag.push_back(tag);
    bus_addr = a; bus_wdata = wd; bus_be = be; bus_rnw = rnw; bus_start = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bus_done && n < 100);
    check(n == exp_n, {tag, " R1 done latency"}, n, exp_n);
    if (!keep) begin
      bus_start = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < NR; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    // R9 outputs in reset
    check(!bus_done && !bus_err && bus_rdata == '0, "R9 reset outputs", bus_rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!bus_done && !bus_err, "R9 idle after reset", {31'd0, bus_done}, 32'd0);
    // R9 registers start at zero
    for (int r = 0; r < NR; r++) xact(16'(r * 4), '0, 4'hF, 1'b1, 1'b0, WAIT, "R9 read reset");
    // R3 full and partial writes
    xact(16'h0000, 32'h11223344, 4'hF, 1'b0, 1'b0, WAIT, "R3 full write");
    xact(16'h0000, 32'hAABBCCDD, 4'b0101, 1'b0, 1'b0, WAIT, "R3 partial write");
    xact(16'h0000, '0, 4'hF, 1'b1, 1'b0, WAIT, "R3 readback");
    xact(16'h001C, 32'hDEADBEEF, 4'b1000, 1'b0, 1'b0, WAIT, "R3 top lane only");
    xact(16'h001C, '0, 4'hF, 1'b1, 1'b0, WAIT, "R3 top readback");
    // R4 read lane masking
    xact(16'h0000, '0, 4'b0010, 1'b1, 1'b0, WAIT, "R4 masked read");
    xact(16'h0000, '0, 4'b0000, 1'b1, 1'b0, WAIT, "R4 no lanes");
    // R8 low address bits ignored
    xact(16'h0007, 32'hCAFEF00D, 4'hF, 1'b0, 1'b0, WAIT, "R8 unaligned write");
    xact(16'h0004, '0, 4'hF, 1'b1, 1'b0, WAIT, "R8 aligned read");
    xact(16'h0006, '0, 4'b1100, 1'b1, 1'b0, WAIT, "R8 unaligned read");
    // R6 out-of-range accesses
    xact(16'h0020, 32'hFFFFFFFF, 4'hF, 1'b0, 1'b0, WAIT, "R6 oor write");
    xact(16'h0020, '0, 4'hF, 1'b1, 1'b0, WAIT, "R6 oor read");
    xact(16'hFFFC, 32'h12345678, 4'hF, 1'b0, 1'b0, WAIT, "R6 far oor write");
    for (int r = 0; r < NR; r++) xact(16'(r * 4), '0, 4'hF, 1'b1, 1'b0, WAIT, "R6 regs unchanged");
    // R2 start kept high across done: the closing edge of done is not counted
    xact(16'h0008, 32'h0BADCAFE, 4'hF, 1'b0, 1'b1, WAIT, "R2 chain first");
    xact(16'h0008, '0, 4'hF, 1'b1, 1'b1, WAIT + 1, "R2 chain second");
    xact(16'h000C, 32'h55AA55AA, 4'b0011, 1'b0, 1'b0, WAIT + 1, "R2 chain third");
    xact(16'h000C, '0, 4'hF, 1'b1, 1'b0, WAIT, "R2 chain readback");
    // R5 write cycles leave read data at zero (checked by the monitor)
    xact(16'h0010, 32'h87654321, 4'hF, 1'b0, 1'b0, WAIT, "R5 write rdata");
    repeat (4) @(negedge clk);
    check(q_data.size() == 0, "R2 responses outstanding", q_data.size(), 32'd0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule